// File: doc/BRIEF.md
# Phase-Accumulator Multi-Waveform Oscillator

This block is one voice of a digital tone generator. A 24-bit phase accumulator advances by a 16-bit frequency word on every clock, and a 23-bit linear feedback shift register supplies pseudo-random noise. A 4-bit waveform code in the control byte picks the 12-bit output: silence, triangle, sawtooth, pulse or noise. Any code with more than one bit set gives silence.

Software loads the frequency, pulse width and control byte through byte-wide writes. Several copies are chained into a ring for hard sync and ring modulation. Each voice receives three signals from its sync source: the source's accumulator MSB, the source's registered MSB-rising pulse, and the source's registered "was synced" flag. Each voice drives the same three signals for the next voice. An 8-bit readback gives the upper bits of the waveform output.

A test bit in the control byte freezes the oscillator at zero and forces the pulse output high. Clearing the test bit reseeds the noise generator.

Top module: `osc_voice`

## Requirements
- R1: After synchronous reset the accumulator, frequency, pulse width and control are zero, `msb_rise` and `synced` are 0, `wave_out` is 0, and the noise register holds 0x7FFFF8. Selecting noise right after reset therefore shows 0xFE0.
- R2: While test is clear and no sync clear occurs, the accumulator adds the frequency word on every clock, modulo 2^24. The sawtooth output (code 2) is accumulator bits 23:12.
- R3: Writes with `wr_en`=1 decode `wr_addr` as follows: 0 = frequency bits 7:0, 1 = frequency bits 15:8, 2 = pulse width bits 7:0, 3 = pulse width bits 11:8 (taken from `wr_data` bits 3:0, upper nibble dropped), 4 = control. Addresses 5 to 7 change nothing.
- R4: Control byte fields: bits 7:4 are the waveform code, bit 3 is test, bit 2 is ring modulation, bit 1 is sync enable. Bit 0 has no effect on any output.
- R5: A control write with test=1 clears the accumulator and the noise register, and both stay at zero while test is set. A control write with test=0 while test was set loads 0x7FFFF8 into the noise register.
- R6: When accumulator bit 19 goes from 0 to 1 on a step, the noise register shifts left by one and takes bit 22 XOR bit 17 into bit 0. The noise output (code 8) places register bits 22, 20, 16, 13, 11, 7, 4 and 2 on output bits 11 down to 4, with bits 3:0 zero.
- R7: The triangle output (code 1) is accumulator bits 22:11, inverted bitwise when the fold bit is 1. Without ring modulation the fold bit is accumulator bit 23.
- R8: With ring modulation set, the triangle fold bit is accumulator bit 23 XOR `src_msb`.
- R9: The pulse output (code 4) is 0xFFF when test is set or when accumulator bits 23:12 are greater than or equal to the pulse width. Otherwise it is 0x000.
- R10: Waveform codes 3, 5, 6, 7 and 9 to 15 give `wave_out` = 0.
- R11: `msb_rise` is high for one cycle in the clock after a step moved accumulator bit 23 from 0 to 1. It stays low while test is set.
- R12: With sync enabled, a clock edge where `src_msb_rise`=1 and `src_synced`=0 clears the accumulator instead of stepping it, and `synced` is 1 in the following cycle. If `src_synced`=1, no clear occurs.
- R13: `osc_rd` equals `wave_out` bits 11:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data byte |
| src_msb | input | 1 | Accumulator MSB of the sync source |
| src_msb_rise | input | 1 | Registered MSB-rising pulse of the sync source |
| src_synced | input | 1 | Source was itself sync-cleared in the same step |
| wave_out | output | 12 | Selected waveform sample |
| osc_rd | output | 8 | Readback of the upper waveform bits |
| acc_msb | output | 1 | Own accumulator MSB, for the next voice |
| msb_rise | output | 1 | Registered own MSB-rising pulse |
| synced | output | 1 | Registered flag: this voice was sync-cleared |

## Verification
The bench uses the default parameters: a 24-bit accumulator, a 16-bit frequency word, a 12-bit output, and the noise clock on accumulator bit 19. At a frequency word of 0xFFFF the accumulator wraps about every 256 cycles and the noise register shifts every 16 cycles. Full sawtooth and triangle periods, MSB rises, many noise shifts and the exact reseed value therefore all occur within a few thousand cycles. The sync inputs are driven straight from the bench, so the clearing case and the same-cycle exception can each be forced on a chosen edge.

// File: rtl/osc_pkg.sv
package osc_pkg;

    localparam int ACC_W     = 24;
    localparam int FREQ_W    = 16;
    localparam int PW_W      = 12;
    localparam int OUT_W     = 12;
    localparam int LFSR_W    = 23;
    localparam int NOISE_BIT = 19;
    localparam int NOISE_TAPS = 8;
    localparam logic [LFSR_W-1:0] NOISE_SEED = 23'h7FFFF8;

    typedef enum logic [2:0] {
        ADDR_FREQ_LO = 3'd0,
        ADDR_FREQ_HI = 3'd1,
        ADDR_PW_LO   = 3'd2,
        ADDR_PW_HI   = 3'd3,
        ADDR_CTRL    = 3'd4
    } reg_addr_e;

    localparam logic [3:0] WAVE_TRI   = 4'h1;
    localparam logic [3:0] WAVE_SAW   = 4'h2;
    localparam logic [3:0] WAVE_PULSE = 4'h4;
    localparam logic [3:0] WAVE_NOISE = 4'h8;

    typedef struct packed {
        logic [3:0] wave;
        logic       test;
        logic       ring;
        logic       sync;
        logic       spare;
    } ctrl_t;

    function automatic int noise_tap(input int k);
        case (k)
            0: return 22;
            1: return 20;
            2: return 16;
            3: return 13;
            4: return 11;
            5: return 7;
            6: return 4;
            default: return 2;
        endcase
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[22] ^ s[17]};
    endfunction

endpackage

// File: rtl/osc_regs.sv
module osc_regs
    import osc_pkg::*;
#(
    parameter int FW = FREQ_W,
    parameter int PW = PW_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [7:0]    wr_data,
    output logic [FW-1:0] freq,
    output logic [PW-1:0] pw,
    output ctrl_t         ctrl,
    output logic          ctrl_wr,
    output logic          ctrl_test_new
);
    localparam int PW_HI_W = PW - 8;

    assign ctrl_wr       = wr_en && (wr_addr == ADDR_CTRL);
    assign ctrl_test_new = wr_data[3];

    always_ff @(posedge clk) begin
        if (rst) begin
            freq <= '0;
            pw   <= '0;
            ctrl <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_FREQ_LO: freq <= {freq[FW-1:8], wr_data};
                ADDR_FREQ_HI: freq <= {wr_data, freq[7:0]};
                ADDR_PW_LO:   pw   <= {pw[PW-1:8], wr_data};
                ADDR_PW_HI:   pw   <= {wr_data[PW_HI_W-1:0], pw[7:0]};
                ADDR_CTRL:    ctrl <= ctrl_t'(wr_data);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/osc_phase.sv
module osc_phase
    import osc_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int FW = FREQ_W,
    parameter int NB = NOISE_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [FW-1:0] freq,
    input  logic          test,
    input  logic          sync_en,
    input  logic          ctrl_wr,
    input  logic          ctrl_test_new,
    input  logic          src_msb_rise,
    input  logic          src_synced,
    output logic [AW-1:0] acc,
    output logic          noise_tick,
    output logic          msb_rise_q,
    output logic          synced_q
);
    localparam int MSB = AW - 1;

    logic [AW-1:0] step_val;
    logic [AW-1:0] sum;
    logic          hit;
    logic          test_arm;

    assign step_val   = AW'(freq);
    assign sum        = acc + step_val;
    assign hit        = sync_en && src_msb_rise && !src_synced;
    assign test_arm   = ctrl_wr && ctrl_test_new;
    assign noise_tick = !test && !acc[NB] && sum[NB];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            msb_rise_q <= 1'b0;
            synced_q   <= 1'b0;
        end else begin
            msb_rise_q <= !test && !acc[MSB] && sum[MSB];
            synced_q   <= hit;
            if (test_arm || test || hit)
                acc <= '0;
            else
                acc <= sum;
        end
    end

    AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
        (!test && !hit && !test_arm) |=> (acc == AW'($past(acc) + $past(step_val)))); // R2

    AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        hit |=> (acc == '0 && synced_q)); // R12

    AST_RISE_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        msb_rise_q |-> !$past(acc[MSB])); // R11
endmodule

// File: rtl/osc_noise.sv
module osc_noise
    import osc_pkg::*;
#(
    parameter int LW = LFSR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          test,
    input  logic          ctrl_wr,
    input  logic          ctrl_test_new,
    input  logic          tick,
    output logic [LW-1:0] lfsr
);
    logic reseed;
    assign reseed = ctrl_wr && !ctrl_test_new && test;

    always_ff @(posedge clk) begin
        if (rst)
            lfsr <= NOISE_SEED;
        else if (ctrl_wr && ctrl_test_new)
            lfsr <= '0;
        else if (reseed)
            lfsr <= NOISE_SEED;
        else if (tick)
            lfsr <= lfsr_next(lfsr);
    end

    AST_RESEED: assert property (@(posedge clk) disable iff (rst)
        reseed |=> (lfsr == NOISE_SEED)); // R5
endmodule

// File: rtl/osc_shaper.sv
module osc_shaper
    import osc_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int PW = PW_W,
    parameter int OW = OUT_W,
    parameter int LW = LFSR_W
) (
    input  logic [AW-1:0] acc,
    input  logic [LW-1:0] lfsr,
    input  logic [PW-1:0] pw,
    input  ctrl_t         ctrl,
    input  logic          src_msb,
    output logic [OW-1:0] wave_out
);
    logic [OW-1:0] saw_v;
    logic [OW-1:0] tri_raw;
    logic [OW-1:0] tri_v;
    logic [OW-1:0] pulse_v;
    logic [OW-1:0] noise_v;
    logic          fold;

    assign saw_v   = acc[AW-1 -: OW];
    assign tri_raw = acc[AW-2 -: OW];
    assign fold    = acc[AW-1] ^ (ctrl.ring & src_msb);
    assign tri_v   = fold ? ~tri_raw : tri_raw;
    assign pulse_v = (ctrl.test || (saw_v >= OW'(pw))) ? '1 : '0;

    for (genvar k = 0; k < NOISE_TAPS; k++) begin : g_tap
        assign noise_v[OW-1-k] = lfsr[noise_tap(k)];
    end
    assign noise_v[OW-NOISE_TAPS-1:0] = '0;

    always_comb begin
        case (ctrl.wave)
            WAVE_TRI:   wave_out = tri_v;
            WAVE_SAW:   wave_out = saw_v;
            WAVE_PULSE: wave_out = pulse_v;
            WAVE_NOISE: wave_out = noise_v;
            default:    wave_out = '0;
        endcase
    end
endmodule

// File: rtl/osc_voice.sv
module osc_voice
    import osc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        src_msb,
    input  logic        src_msb_rise,
    input  logic        src_synced,
    output logic [11:0] wave_out,
    output logic [7:0]  osc_rd,
    output logic        acc_msb,
    output logic        msb_rise,
    output logic        synced
);
    logic [FREQ_W-1:0] freq;
    logic [PW_W-1:0]   pw;
    ctrl_t             ctrl;
    logic              ctrl_wr;
    logic              ctrl_test_new;
    logic [ACC_W-1:0]  acc;
    logic [LFSR_W-1:0] lfsr;
    logic              noise_tick;

    osc_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .freq(freq), .pw(pw), .ctrl(ctrl), .ctrl_wr(ctrl_wr), .ctrl_test_new(ctrl_test_new)
    );

    osc_phase u_phase (
        .clk(clk), .rst(rst), .freq(freq), .test(ctrl.test), .sync_en(ctrl.sync),
        .ctrl_wr(ctrl_wr), .ctrl_test_new(ctrl_test_new),
        .src_msb_rise(src_msb_rise), .src_synced(src_synced),
        .acc(acc), .noise_tick(noise_tick), .msb_rise_q(msb_rise), .synced_q(synced)
    );

    osc_noise u_noise (
        .clk(clk), .rst(rst), .test(ctrl.test), .ctrl_wr(ctrl_wr),
        .ctrl_test_new(ctrl_test_new), .tick(noise_tick), .lfsr(lfsr)
    );

    osc_shaper u_shaper (
        .acc(acc), .lfsr(lfsr), .pw(pw), .ctrl(ctrl), .src_msb(src_msb),
        .wave_out(wave_out)
    );

    assign acc_msb = acc[ACC_W-1];
    assign osc_rd  = wave_out[OUT_W-1 -: 8];

    AST_TEST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ctrl.test |-> (acc == '0 && lfsr == '0 && !msb_rise)); // R5

    AST_TEST_PULSE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (ctrl.test && ctrl.wave == WAVE_PULSE) |-> (wave_out == '1)); // R9

    AST_MULTI_SILENT: assert property (@(posedge clk) disable iff (rst)
        ($countones(ctrl.wave) > 1) |-> (wave_out == '0)); // R10
endmodule

// File: tb/osc_voice_test.sv
`timescale 1ns/1ps
module osc_voice_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        src_msb = 1'b0;
    logic        src_msb_rise = 1'b0;
    logic        src_synced = 1'b0;
    logic [11:0] wave_out;
    logic [7:0]  osc_rd;
    logic        acc_msb;
    logic        msb_rise;
    logic        synced;

    always #4 clk = ~clk;

    osc_voice uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .src_msb(src_msb), .src_msb_rise(src_msb_rise), .src_synced(src_synced),
        .wave_out(wave_out), .osc_rd(osc_rd), .acc_msb(acc_msb),
        .msb_rise(msb_rise), .synced(synced)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_req = "R1";

    // stimulus for the sync-source side
    logic s_msb = 0, s_rise = 0, s_synced = 0;

    // behavioural reference state
    logic [23:0] m_acc;
    logic [22:0] m_lfsr;
    logic [15:0] m_freq;
    logic [11:0] m_pw;
    logic [7:0]  m_ctrl;
    logic        m_rise, m_syn;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_wave();
        logic [11:0] t, s;
        logic f;
        s = m_acc[23:12];
        case (m_ctrl[7:4])
            4'd1: begin
                f = m_acc[23] ^ (m_ctrl[2] & s_msb);
                t = m_acc[22:11];
                return f ? ~t : t;
            end
            4'd2: return s;
            4'd4: return (m_ctrl[3] || s >= m_pw) ? 12'hFFF : 12'h000;
            4'd8: return {m_lfsr[22], m_lfsr[20], m_lfsr[16], m_lfsr[13],
                          m_lfsr[11], m_lfsr[7], m_lfsr[4], m_lfsr[2], 4'h0};
            default: return 12'h000;
        endcase
    endfunction

    task automatic compare();
        logic [11:0] e;
        e = exp_wave();
        chk(cur_req, "wave_out", int'(wave_out), int'(e));
        chk("R13", "osc_rd", int'(osc_rd), int'(e[11:4]));
        chk("R11", "msb_rise", int'(msb_rise), int'(m_rise));
        chk("R12", "synced", int'(synced), int'(m_syn));
    endtask

    task automatic model_reset();
        m_acc = 0; m_lfsr = 23'h7FFFF8; m_freq = 0; m_pw = 0; m_ctrl = 0;
        m_rise = 0; m_syn = 0;
    endtask

    task automatic cyc(input logic we, input logic [2:0] a, input logic [7:0] d);
        logic [23:0] sum, n_acc;
        logic [22:0] n_lfsr;
        logic [15:0] n_freq;
        logic [11:0] n_pw;
        logic [7:0]  n_ctrl;
        logic hit, tst, n_rise;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        src_msb = s_msb; src_msb_rise = s_rise; src_synced = s_synced;
        sum = m_acc + {8'h00, m_freq};
        tst = m_ctrl[3];
        hit = m_ctrl[1] && s_rise && !s_synced;
        n_rise = !tst && !m_acc[23] && sum[23];
        n_lfsr = m_lfsr;
        if (!tst && !m_acc[19] && sum[19])
            n_lfsr = {m_lfsr[21:0], m_lfsr[22] ^ m_lfsr[17]};
        n_acc = (tst || hit) ? 24'h0 : sum;
        n_freq = m_freq; n_pw = m_pw; n_ctrl = m_ctrl;
        if (we) begin
            case (a)
                3'd0: n_freq[7:0] = d;
                3'd1: n_freq[15:8] = d;
                3'd2: n_pw[7:0] = d;
                3'd3: n_pw[11:8] = d[3:0];
                3'd4: begin
                    n_ctrl = d;
                    if (d[3]) begin n_acc = 0; n_lfsr = 0; end
                    else if (tst) n_lfsr = 23'h7FFFF8;
                end
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        m_acc = n_acc; m_lfsr = n_lfsr; m_freq = n_freq; m_pw = n_pw; m_ctrl = n_ctrl;
        m_rise = n_rise; m_syn = hit;
        compare();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cyc(1'b1, a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'h00);
    endtask

    task automatic set_freq(input logic [15:0] f);
        wr(3'd0, f[7:0]);
        wr(3'd1, f[15:8]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; wr_en = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        compare();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state and noise seed
        cur_req = "R1";
        do_reset();
        chk("R1", "wave after reset", int'(wave_out), 0);
        chk("R1", "msb_rise after reset", int'(msb_rise), 0);
        wr(3'd4, 8'h80);
        chk("R1", "noise seed pattern", int'(wave_out), 'hFE0);

        // R2/R3: sawtooth at two frequencies, wrap included
        cur_req = "R2";
        set_freq(16'h1234);
        wr(3'd4, 8'h20);
        idle(300);
        set_freq(16'hFFFF);
        idle(600);

        // R3: unused addresses ignored, pulse width high nibble only
        cur_req = "R3";
        wr(3'd5, 8'h00);
        wr(3'd6, 8'h88);
        wr(3'd7, 8'hFF);
        idle(5);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'hF5);
        wr(3'd4, 8'h40);
        idle(300);

        // R4: spare control bit has no effect
        cur_req = "R4";
        wr(3'd4, 8'h21);
        idle(100);
        wr(3'd4, 8'h20);
        idle(50);

        // R7: triangle
        cur_req = "R7";
        wr(3'd4, 8'h10);
        idle(600);

        // R8: ring modulated triangle with a toggling source MSB
        cur_req = "R8";
        set_freq(16'h4000);
        wr(3'd4, 8'h14);
        for (int i = 0; i < 400; i++) begin
            s_msb = ((i % 7) < 3);
            cyc(1'b0, 3'd0, 8'h00);
        end
        s_msb = 0;

        // R9: pulse at several widths
        cur_req = "R9";
        set_freq(16'hFFFF);
        wr(3'd4, 8'h40);
        wr(3'd2, 8'h00); wr(3'd3, 8'h08);
        idle(300);
        wr(3'd3, 8'h00);
        idle(100);
        wr(3'd2, 8'hFF); wr(3'd3, 8'h0F);
        idle(300);

        // R6: noise stepping at two rates
        cur_req = "R6";
        wr(3'd4, 8'h80);
        idle(2000);
        set_freq(16'h0123);
        idle(1500);

        // R5: test bit freezes, pulse forced high, reseed on release
        cur_req = "R5";
        set_freq(16'hFFFF);
        wr(3'd4, 8'h88);
        chk("R5", "noise under test", int'(wave_out), 0);
        idle(40);
        wr(3'd4, 8'h48);
        chk("R5", "pulse under test", int'(wave_out), 'hFFF);
        idle(20);
        wr(3'd4, 8'h80);
        chk("R5", "noise after release", int'(wave_out), 'hFE0);
        idle(200);

        // R10: multi-bit codes are silent
        cur_req = "R10";
        for (int c = 3; c < 16; c++) begin
            if (c != 4 && c != 8) begin
                wr(3'd4, 8'(c << 4));
                idle(30);
                chk("R10", "multi-bit code", int'(wave_out), 0);
            end
        end

        // R11: MSB rise pulses over several wraps
        cur_req = "R11";
        wr(3'd4, 8'h20);
        idle(800);

        // R12: hard sync clear and the same-cycle exception
        cur_req = "R12";
        set_freq(16'h1000);
        wr(3'd4, 8'h22);
        idle(50);
        s_rise = 1; s_synced = 0;
        cyc(1'b0, 3'd0, 8'h00);
        s_rise = 0;
        chk("R12", "sync cleared saw", int'(wave_out), 0);
        chk("R12", "synced flag", int'(synced), 1);
        idle(30);
        s_rise = 1; s_synced = 1;
        cyc(1'b0, 3'd0, 8'h00);
        s_rise = 0; s_synced = 0;
        chk("R12", "exception keeps phase", int'(wave_out == 0), 0);
        idle(20);
        wr(3'd4, 8'h20);
        s_rise = 1;
        cyc(1'b0, 3'd0, 8'h00);
        s_rise = 0;
        idle(20);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule